// File: doc/BRIEF.md
# Limited-Pointer Sharer Directory

This block is the memory-side coherence record for a small set of memory blocks. It does not keep a presence bit for every processor. Instead, each block's entry holds a fixed number of pointer slots, and each slot names one caching processor by its binary number. The slot count does not depend on the processor count. An entry also carries a dirty flag, which marks that one processor holds the only writable copy; that owner always sits in slot 0. Broadcast is never used, so the number of cached copies of a block can never exceed the slot count.

Requests arrive one at a time. Each names a processor, a block, and whether write access is wanted. When a request needs other caches to drop their copies, the directory issues invalidations one at a time on an invalidate channel. It waits for the matching acknowledgement before it moves on, and it returns the grant only after the last acknowledgement. A read that finds every slot taken evicts one sharer, chosen round-robin per entry, and gives that slot to the reader. A write clears all other sharers and leaves the writer as the dirty owner. The caches, the interconnect and the data storage sit outside this block.

Top module: `limptr_dir`

## Requirements
- R1: After reset, req_ready is 1 and inv_valid and grant_valid are 0. Every entry is empty, so the first read of any block is granted with no invalidation.
- R2: A read by a processor that is not recorded, on a clean entry with a free slot, takes the lowest free slot. It is granted (grant_write 0) in the cycle after the request is accepted, with no invalidation.
- R3: A read by a processor already held in a slot does not take a second slot. It is granted with no invalidation.
- R4: A read by an unrecorded processor when every slot is valid invalidates exactly one current sharer. That sharer's slot is handed to the reader, and the grant follows the acknowledgement.
- R5: The eviction victim is the slot given by a per-entry round-robin index. The index starts at slot 0 and moves to the next slot (wrapping) after each eviction. Writes and other reads leave it unchanged.
- R6: A write invalidates every recorded sharer other than the writer, lowest slot first and one per acknowledgement. grant_write 1 follows the last acknowledgement, and afterwards the entry is dirty with the writer as its only holder.
- R7: A read or write by the owner of a dirty entry is granted with no invalidation and leaves the entry unchanged.
- R8: A read of a dirty entry by another processor invalidates the owner. Afterwards the entry is clean with the reader as its only sharer.
- R9: inv_valid stays high with a stable inv_proc until ack_valid arrives with ack_proc equal to inv_proc. An acknowledgement carrying another number has no effect.
- R10: While invalidations are outstanding, req_ready is 0 and any request presented is dropped.
- R11: Each block's entry changes only on requests that name that block.
- R12: grant_valid and inv_valid are never high in the same cycle, and an invalidation starts only in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_write | input | 1 | 1 = write access wanted, 0 = read |
| req_proc | input | clog2(N_PROC) | Requesting processor number |
| req_block | input | clog2(BLOCKS) | Block index |
| inv_valid | output | 1 | Invalidate command outstanding |
| inv_proc | output | clog2(N_PROC) | Processor to invalidate |
| ack_valid | input | 1 | Invalidate acknowledgement |
| ack_proc | input | clog2(N_PROC) | Processor acknowledging |
| grant_valid | output | 1 | One-cycle grant pulse |
| grant_write | output | 1 | Grant is for write access |
| grant_proc | output | clog2(N_PROC) | Processor granted |
| grant_block | output | clog2(BLOCKS) | Block granted |

## Verification
The hardest state to reach from the ports is a full entry whose round-robin index has been advanced by earlier evictions and then survived a write and a dirty-read recovery. Only a later eviction shows which victim the index now points at. The stimulus table walks a single block through three evictions, an ownership write, an owner read, a foreign read of the dirty line and a refill. It then checks that the next eviction lands on slot 1. A directed sequence then holds an eviction open while it presents a mismatched acknowledgement and a competing write. The following eviction's victim shows that neither one touched the entry.

// File: rtl/limptr_dir.sv
module limptr_dir #(
  parameter int N_PROC = 8,
  parameter int SLOTS  = 2,
  parameter int BLOCKS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [$clog2(N_PROC)-1:0] req_proc,
  input  logic [$clog2(BLOCKS)-1:0] req_block,
  output logic                      inv_valid,
  output logic [$clog2(N_PROC)-1:0] inv_proc,
  input  logic                      ack_valid,
  input  logic [$clog2(N_PROC)-1:0] ack_proc,
  output logic                      grant_valid,
  output logic                      grant_write,
  output logic [$clog2(N_PROC)-1:0] grant_proc,
  output logic [$clog2(BLOCKS)-1:0] grant_block
);
  localparam int PW = $clog2(N_PROC);
  localparam int BW = $clog2(BLOCKS);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [PW-1:0]    ptr   [BLOCKS][SLOTS];
  logic [SLOTS-1:0] vld   [BLOCKS];
  logic [SW-1:0]    rr    [BLOCKS];
  logic [BLOCKS-1:0] dirty;

  logic          busy, cur_wr;
  logic [PW-1:0] cur_proc;
  logic [BW-1:0] cur_blk;
  logic [SLOTS-1:0] pend;

  logic          sel_wr;
  logic [PW-1:0] sel_proc;
  logic [BW-1:0] sel_blk;
  assign sel_wr   = busy ? cur_wr   : req_write;
  assign sel_proc = busy ? cur_proc : req_proc;
  assign sel_blk  = busy ? cur_blk  : req_block;

  logic [SLOTS-1:0] e_vld, hit, need;
  logic             e_dirty, have_free, owner_self;
  logic [SW-1:0]    e_rr, free_idx;

  always_comb begin
    e_vld   = vld[sel_blk];
    e_dirty = dirty[sel_blk];
    e_rr    = rr[sel_blk];
    have_free = 1'b0;
    free_idx  = '0;
    for (int s = 0; s < SLOTS; s++)
      hit[s] = e_vld[s] && (ptr[sel_blk][s] == sel_proc);
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!e_vld[s]) begin
        have_free = 1'b1;
        free_idx  = SW'(s);
      end
    owner_self = e_dirty && hit[0];
    need = '0;
    if (sel_wr)        need = e_vld & ~hit;
    else if (e_dirty)  need = owner_self ? '0 : e_vld;
    else if (hit == '0 && !have_free) need[e_rr] = 1'b1;
  end

  logic [SW-1:0]    lo;
  logic [SLOTS-1:0] pend_next;
  always_comb begin
    lo = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (pend[s]) lo = SW'(s);
    pend_next = pend;
    pend_next[lo] = 1'b0;
  end

  logic accept, ack_ok, apply;
  assign req_ready = !busy;
  assign inv_valid = busy;
  assign inv_proc  = ptr[cur_blk][lo];
  assign accept    = !busy && req_valid;
  assign ack_ok    = busy && ack_valid && (ack_proc == inv_proc);
  assign apply     = (accept && need == '0) || (ack_ok && pend_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pend <= '0; cur_wr <= 1'b0; cur_proc <= '0; cur_blk <= '0;
      grant_valid <= 1'b0; grant_write <= 1'b0; grant_proc <= '0; grant_block <= '0;
      dirty <= '0;
      for (int b = 0; b < BLOCKS; b++) begin
        vld[b] <= '0;
        rr[b]  <= '0;
        for (int s = 0; s < SLOTS; s++) ptr[b][s] <= '0;
      end
    end else begin
      grant_valid <= apply;
      if (apply) begin
        grant_write <= sel_wr;
        grant_proc  <= sel_proc;
        grant_block <= sel_blk;
      end
      if (accept && need != '0) begin
        busy <= 1'b1; pend <= need;
        cur_wr <= req_write; cur_proc <= req_proc; cur_blk <= req_block;
      end
      if (ack_ok) begin
        pend <= pend_next;
        if (pend_next == '0) busy <= 1'b0;
      end
      if (apply) begin
        if (sel_wr) begin
          vld[sel_blk]    <= SLOTS'(1);
          ptr[sel_blk][0] <= sel_proc;
          dirty[sel_blk]  <= 1'b1;
        end else if (e_dirty) begin
          if (!owner_self) begin
            vld[sel_blk]    <= SLOTS'(1);
            ptr[sel_blk][0] <= sel_proc;
            dirty[sel_blk]  <= 1'b0;
          end
        end else if (hit == '0) begin
          if (have_free) begin
            vld[sel_blk][free_idx] <= 1'b1;
            ptr[sel_blk][free_idx] <= sel_proc;
          end else begin
            ptr[sel_blk][e_rr] <= sel_proc;
            rr[sel_blk] <= (e_rr == SW'(SLOTS - 1)) ? '0 : e_rr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/limptr_dir_props.sv
module limptr_dir_props #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          inv_valid,
  input logic [PW-1:0] inv_proc,
  input logic          ack_valid,
  input logic [PW-1:0] ack_proc,
  input logic          grant_valid
);
  assert_grant_or_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (grant_valid || inv_valid));

  assert_ack_progress_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && ack_valid && ack_proc == inv_proc) |=> (inv_valid || grant_valid));

  assert_inv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !(ack_valid && ack_proc == inv_proc)) |=> (inv_valid && $stable(inv_proc)));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !req_ready);

  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && inv_valid));

  assert_inv_origin_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inv_valid) |-> $past(req_valid && req_ready));
endmodule

bind limptr_dir limptr_dir_props #(.PW(PW)) u_props (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .inv_valid(inv_valid), .inv_proc(inv_proc), .ack_valid(ack_valid),
  .ack_proc(ack_proc), .grant_valid(grant_valid)
);

// File: tb/limptr_dir_bench.sv
module limptr_dir_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ack_valid = 0;
  logic [2:0] req_proc = 0, ack_proc = 0;
  logic [1:0] req_block = 0;
  logic req_ready, inv_valid, grant_valid, grant_write;
  logic [2:0] inv_proc, grant_proc;
  logic [1:0] grant_block;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  limptr_dir #(.N_PROC(8), .SLOTS(2), .BLOCKS(4)) u_limptr_dir (.*);

  // {write, proc, block, n_inv, first_inv, second_inv}
  localparam logic [13:0] VEC [20] = '{
    {1'b0,3'd1,2'd0,2'd0,3'd0,3'd0}, // R1 empty entry
    {1'b0,3'd1,2'd0,2'd0,3'd0,3'd0}, // R3 repeat reader
    {1'b0,3'd2,2'd0,2'd0,3'd0,3'd0}, // R3 fits without eviction
    {1'b0,3'd3,2'd0,2'd1,3'd1,3'd0}, // R4 evict slot0
    {1'b0,3'd4,2'd0,2'd1,3'd2,3'd0}, // R5 evict slot1
    {1'b0,3'd5,2'd0,2'd1,3'd3,3'd0}, // R5 wrap to slot0
    {1'b1,3'd4,2'd0,2'd1,3'd5,3'd0}, // R6 sharer writes
    {1'b1,3'd4,2'd0,2'd0,3'd0,3'd0}, // R7 owner writes again
    {1'b0,3'd6,2'd0,2'd1,3'd4,3'd0}, // R8 foreign read of dirty
    {1'b0,3'd7,2'd0,2'd0,3'd0,3'd0}, // R8 second slot now free
    {1'b1,3'd0,2'd0,2'd2,3'd6,3'd7}, // R6 two invalidations in slot order
    {1'b0,3'd0,2'd0,2'd0,3'd0,3'd0}, // R7 owner reads
    {1'b0,3'd1,2'd1,2'd0,3'd0,3'd0}, // R11 other block empty
    {1'b1,3'd2,2'd1,2'd1,3'd1,3'd0}, // R11 write other block
    {1'b0,3'd3,2'd0,2'd1,3'd0,3'd0}, // R8 block0 owner unaffected by block1
    {1'b0,3'd4,2'd0,2'd0,3'd0,3'd0}, // R2 lowest free slot
    {1'b0,3'd5,2'd0,2'd1,3'd4,3'd0}, // R5 index kept through write
    {1'b0,3'd6,2'd0,2'd1,3'd3,3'd0}, // R5 wrap again
    {1'b1,3'd5,2'd2,2'd0,3'd0,3'd0}, // R6 write to empty entry
    {1'b0,3'd5,2'd2,2'd0,3'd0,3'd0}  // R7 owner read
  };
  string TAG [20] = '{"R1","R3","R3","R4","R5","R5","R6","R7","R8","R8",
                      "R6","R7","R11","R11","R8","R2","R5","R5","R6","R7"};

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run_req(input bit wr, input int p, input int b, input int n_exp,
                         input int e0, input int e1, input string tag);
    int cnt = 0, g0 = -1, g1 = -1, cyc = 0;
    bit done = 0;
    @(negedge clk);
    chk(req_ready == 1, tag, "ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_proc = 3'(p); req_block = 2'(b);
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    while (!done && cyc < 50) begin
      if (grant_valid) begin
        done = 1;
        chk(grant_proc == 3'(p) && grant_block == 2'(b) && grant_write == wr, tag,
            "grant proc", grant_proc, p);
        if (n_exp == 0) chk(cyc == 0, tag, "grant latency", cyc, 0);
      end else if (inv_valid) begin
        if (cnt == 0) g0 = inv_proc; else g1 = inv_proc;
        cnt++;
        ack_valid = 1; ack_proc = inv_proc;
        @(posedge clk); @(negedge clk);
        ack_valid = 0;
      end else begin
        @(posedge clk); @(negedge clk);
      end
      cyc++;
    end
    chk(done, tag, "grant seen", done, 1);
    chk(cnt == n_exp, tag, "invalidate count", cnt, n_exp);
    if (n_exp > 0) chk(g0 == e0, tag, "first victim", g0, e0);
    if (n_exp > 1) chk(g1 == e1, tag, "second victim", g1, e1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
    chk(inv_valid == 0, "R1", "reset inv_valid", inv_valid, 0);
    chk(grant_valid == 0, "R1", "reset grant_valid", grant_valid, 0);

    for (int k = 0; k < 20; k++)
      run_req(VEC[k][13], VEC[k][12:10], VEC[k][9:8], VEC[k][7:6],
              VEC[k][5:3], VEC[k][2:0], TAG[k]);

    run_req(0, 1, 3, 0, 0, 0, "R1");
    run_req(0, 2, 3, 0, 0, 0, "R2");
    @(negedge clk);
    req_valid = 1; req_write = 0; req_proc = 3; req_block = 3;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(inv_valid == 1 && inv_proc == 1, "R4", "eviction of slot0", inv_proc, 1);
    chk(req_ready == 0, "R10", "ready while busy", req_ready, 0);
    req_valid = 1; req_write = 1; req_proc = 6; req_block = 3;
    ack_valid = 1; ack_proc = 5;
    @(posedge clk); @(negedge clk);
    req_valid = 0; ack_valid = 0;
    chk(inv_valid == 1 && inv_proc == 1, "R9", "inv held after wrong ack", inv_proc, 1);
    chk(grant_valid == 0, "R9", "no grant after wrong ack", grant_valid, 0);
    ack_valid = 1; ack_proc = 1;
    @(posedge clk); @(negedge clk);
    ack_valid = 0;
    chk(grant_valid == 1 && grant_proc == 3 && grant_write == 0, "R4", "grant after ack",
        grant_proc, 3);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(grant_valid == 0 && inv_valid == 0, "R10", "dropped request idle",
          grant_valid, 0);
    end
    run_req(0, 6, 3, 1, 2, 0, "R10");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule